// File: doc/BRIEF.md
# Serial Challenge-Response Security Latch

This block is the slave side of a small serial authentication scheme. A host pulls an active-low select line, toggles a serial clock and shifts bits in. The latch answers on one data-out line with bits from an 8-bit secret-dependent state. Whenever a session opens, the state is preset and then passed once through a fixed linear start map. After that, each serial clock cycle returns one state bit, least significant position first. When the bit the host sends for that cycle is zero, the state is also rewritten by a keyed linear map that belongs to the current bit position.

The keyed maps come from one 64-bit key parameter that gives the coefficients for position 0. The maps for positions 1 to 7 are derived from it in hardware. No line marks the end of a byte, so the position counter simply wraps. All serial timing comes from the edges of the serial clock, which is oversampled in the system clock domain. Any serial rate works as long as each serial half-period spans at least four system clocks.

Top module: `auth_latch_top`

## Requirements
- R1: While select (`sel_n`) is high, and from reset onward, `sdo` is 1.
- R2: When `sel_n` falls, the state becomes the start map of 0xFC, which is 0xAB, and the position counter becomes 0. Bit 0 of that state appears on `sdo` before the first rising serial clock edge. The start map XORs masks 0xFF, 0xFE, 0xFC, 0xF8, 0xF0, 0xE0, 0xC0 and 0x7F, one for each set state bit 0 through 7.
- R3: At position n, `sdo` shows bit n of the current state. It changes only on a falling `sclk` edge or on a select change, so it is stable when the host samples it at the rising edge.
- R4: If `sdi` is 1 at a rising `sclk` edge, the state is left unchanged.
- R5: If `sdi` is 0 at a rising `sclk` edge at position n, the state becomes the XOR of coefficient bytes c[n][b] over every set state bit b.
- R6: The position counter advances by one on each rising `sclk` edge during a session and wraps from 7 to 0. Bytes follow each other with no separator.
- R7: Raising `sel_n` in the middle of a byte ends the session. The next falling edge of `sel_n` starts again from R2.
- R8: Behaviour depends only on `sclk` edges, not on a fixed rate. Sessions at different serial rates with the same inputs give the same bits.
- R9: Byte b of `KEY` (bits 8b+7..8b) is c[0][b]. Let Sh(x) = {x[6:0], x[7]^x[6]}. For n ≥ 1, c[n][b] = Sh(c[n-1][b-1]) for b = 1..6, c[n][0] = Sh(c[n-1][7]), and c[n][7] = Sh(c[n-1][6]) ^ c[n][0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low session select from host |
| sclk | input | 1 | Serial clock from host, idle high |
| sdi | input | 1 | Serial data from host, one bit per sclk cycle |
| sdo | output | 1 | Serial response bit, LSB position first |

## Verification
The assertions take for granted that `sclk`, `sdi` and `sel_n` are slow next to `clk`. In particular, `sdi` must be settled and the same through the synchroniser delay around each rising `sclk` edge, and select must not change on the same system cycle as a serial edge. The stimulus changes `sdi` only together with the falling `sclk` edge. Every serial half-period is held to at least four system clocks, in both a slow and a fast session. Select moves only while `sclk` is high and has been quiet for a full half-period.

// File: rtl/auth_latch_pkg.sv
package auth_latch_pkg;
    localparam int ST_W      = 8;
    localparam int NPOS      = 8;
    localparam int CNT_W     = $clog2(NPOS);
    localparam int MAP_W     = ST_W * ST_W;
    localparam int TAB_W     = NPOS * MAP_W;
    localparam logic [ST_W-1:0] PRESET = 8'hFC;

    typedef logic [ST_W-1:0]  state_t;
    typedef logic [CNT_W-1:0] pos_t;

    function automatic state_t shift_mix(input state_t x);
        return {x[ST_W-2:0], x[ST_W-1] ^ x[ST_W-2]};
    endfunction

    function automatic state_t start_map(input state_t s);
        state_t r;
        state_t m;
        r = '0;
        for (int i = 0; i < ST_W; i++) begin
            m = (i == ST_W - 1) ? 8'h7F : state_t'(8'hFF << i);
            if (s[i]) r = r ^ m;
        end
        return r;
    endfunction

    function automatic state_t keyed_map(input state_t s, input logic [MAP_W-1:0] cf);
        state_t r;
        r = '0;
        for (int b = 0; b < ST_W; b++)
            if (s[b]) r = r ^ cf[b*ST_W +: ST_W];
        return r;
    endfunction

    localparam state_t START_ST = start_map(PRESET);
endpackage

// File: rtl/auth_latch_sync.sv
module auth_latch_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_i;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: RST_VAL, stab: RST_VAL};
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stab;
endmodule

// File: rtl/auth_latch_keytab.sv
module auth_latch_keytab
    import auth_latch_pkg::*;
#(
    parameter logic [MAP_W-1:0] KEY = 64'h1D2B_4C87_93E1_5A6F
) (
    output logic [TAB_W-1:0] tab_o
);
    state_t c [NPOS][ST_W];

    for (genvar n = 0; n < NPOS; n++) begin : g_pos
        if (n == 0) begin : g_base
            for (genvar b = 0; b < ST_W; b++) begin : g_b
                assign c[0][b] = KEY[b*ST_W +: ST_W];
            end
        end else begin : g_derived
            assign c[n][0] = shift_mix(c[n-1][ST_W-1]);
            for (genvar b = 1; b < ST_W - 1; b++) begin : g_mid
                assign c[n][b] = shift_mix(c[n-1][b-1]);
            end
            assign c[n][ST_W-1] = shift_mix(c[n-1][ST_W-2]) ^ shift_mix(c[n-1][ST_W-1]);
        end
        for (genvar b = 0; b < ST_W; b++) begin : g_flat
            assign tab_o[(n*ST_W + b)*ST_W +: ST_W] = c[n][b];
        end
    end
endmodule

// File: rtl/auth_latch_core.sv
module auth_latch_core
    import auth_latch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_s,
    input  logic             sclk_s,
    input  logic             sdi_s,
    input  logic [TAB_W-1:0] tab_i,
    output logic             sdo_o
);
    typedef struct packed {
        logic   sclk_prev;
        logic   sel_prev;
        state_t state;
        pos_t   pos;
        logic   sdo;
    } core_t;

    core_t c_d, c_q;
    logic  rise, fall, in_sess;
    logic [MAP_W-1:0] cf_now;

    assign rise    = sclk_s & ~c_q.sclk_prev;
    assign fall    = ~sclk_s & c_q.sclk_prev;
    assign in_sess = sel_s & c_q.sel_prev;
    assign cf_now  = tab_i[c_q.pos*MAP_W +: MAP_W];

    always_comb begin
        c_d           = c_q;
        c_d.sclk_prev = sclk_s;
        c_d.sel_prev  = sel_s;
        if (!sel_s) begin
            c_d.sdo = 1'b1;
        end else if (!c_q.sel_prev) begin
            c_d.state = START_ST;
            c_d.pos   = '0;
            c_d.sdo   = START_ST[0];
        end else if (rise) begin
            if (!sdi_s) c_d.state = keyed_map(c_q.state, cf_now);
            c_d.pos = c_q.pos + pos_t'(1);
        end else if (fall) begin
            c_d.sdo = c_q.state[c_q.pos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{sclk_prev: 1'b1, sel_prev: 1'b0, state: PRESET, pos: '0, sdo: 1'b1};
        else        c_q <= c_d;
    end

    assign sdo_o = c_q.sdo;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> sdo_o);

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && !c_q.sel_prev) |=> (c_q.state == START_ST && c_q.pos == '0));

    assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sess && !fall) |=> $stable(sdo_o));

    assert_hold_on_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sess && rise && sdi_s) |=> $stable(c_q.state));

    assert_pos_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sess && rise) |=> (c_q.pos == $past(c_q.pos) + pos_t'(1)));
endmodule

// File: rtl/auth_latch_top.sv
module auth_latch_top
    import auth_latch_pkg::*;
#(
    parameter logic [MAP_W-1:0] KEY = 64'h1D2B_4C87_93E1_5A6F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    logic [2:0]       raw, synced;
    logic [TAB_W-1:0] tab;

    assign raw = {sel_n, sclk, sdi};

    auth_latch_sync #(.WIDTH(3), .RST_VAL(3'b111)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    auth_latch_keytab #(.KEY(KEY)) keytab_i (
        .tab_o (tab)
    );

    auth_latch_core core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_s  (~synced[2]),
        .sclk_s (synced[1]),
        .sdi_s  (synced[0]),
        .tab_i  (tab),
        .sdo_o  (sdo)
    );
endmodule

// File: tb/auth_latch_top_tb_top.sv
module auth_latch_top_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] TB_KEY     = 64'hA5C3_0F96_3E71_D248;
    localparam int          SLOW_H     = 200;
    localparam int          FAST_H     = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b1, sdi = 1'b1;
    logic sdo;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t exp_q[$];
    event  sample_ev;

    logic [7:0] cf [8][8];
    logic [7:0] m_st;
    int         m_pos;

    auth_latch_top #(.KEY(TB_KEY)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi), .sdo(sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] sh(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[6]};
    endfunction

    // Monitor: pops expectations and compares with sdo
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (sdo !== it.exp) begin
                    failures++;
                    $display("FAIL %s: sdo=%b expected=%b", it.tag, sdo, it.exp);
                end
            end
        end
    end

    task automatic push_check(input logic e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        ->sample_ev;
        #1;
    endtask

    task automatic open_sess(input int h);
        sel_n = 1'b0;
        m_st  = 8'hAB;   // R2: start map of 0xFC
        m_pos = 0;
        #(h);
    endtask

    task automatic close_sess(input int h);
        sel_n = 1'b1;
        #(h);
        push_check(1'b1, "R1/R7 idle after deselect");
    endtask

    task automatic send_bit(input logic b, input int h, input string tag);
        logic [7:0] r;
        sclk = 1'b0;
        sdi  = b;
        #(h);
        push_check(m_st[m_pos], tag);
        sclk = 1'b1;
        #(h - 1);
        if (!b) begin
            r = '0;
            for (int k = 0; k < 8; k++) if (m_st[k]) r = r ^ cf[m_pos][k];
            m_st = r;
        end
        m_pos = (m_pos + 1) % 8;
    endtask

    task automatic send_byte(input logic [7:0] v, input int h, input string tag);
        for (int i = 0; i < 8; i++) send_bit(v[i], h, tag);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] first_resp [4];
        // R9: coefficient table from key, c[n][7] via c[n][0]
        for (int b = 0; b < 8; b++) cf[0][b] = TB_KEY[b*8 +: 8];
        for (int n = 1; n < 8; n++) begin
            for (int b = 0; b < 7; b++) cf[n][b] = sh(cf[n-1][(b + 7) % 8]);
            cf[n][7] = sh(cf[n-1][6]) ^ cf[n][0];
        end

        #3;
        #(CLK_PERIOD * 4);
        push_check(1'b1, "R1 reset idle");
        rst_n = 1'b1;
        #(CLK_PERIOD * 5);
        push_check(1'b1, "R1 idle after reset");

        // R2/R3/R4: all ones leaves 0xAB, bits LSB first
        open_sess(SLOW_H);
        push_check(1'b1, "R2 bit0 before first rise");
        send_byte(8'hFF, SLOW_H, "R4 hold on one");
        send_byte(8'hFF, SLOW_H, "R6 second byte wraps");
        close_sess(SLOW_H);

        // R5/R6/R9: all zeros over several bytes
        open_sess(SLOW_H);
        send_byte(8'h00, SLOW_H, "R5 keyed zeros");
        send_byte(8'h00, SLOW_H, "R6 wrap keyed");
        send_byte(8'h00, SLOW_H, "R9 derived coef");
        close_sess(SLOW_H);

        // Mixed patterns, slow rate
        open_sess(SLOW_H);
        send_byte(8'h5A, SLOW_H, "R5 pattern 5A");
        send_byte(8'h3C, SLOW_H, "R3 pattern 3C");
        send_byte(8'hE1, SLOW_H, "R5 pattern E1");
        close_sess(SLOW_H);

        // R7: abort mid-byte then restart from position 0
        open_sess(SLOW_H);
        send_bit(1'b0, SLOW_H, "R7 pre-abort");
        send_bit(1'b0, SLOW_H, "R7 pre-abort");
        send_bit(1'b1, SLOW_H, "R7 pre-abort");
        close_sess(SLOW_H);
        open_sess(SLOW_H);
        push_check(1'b1, "R7 restart bit0");
        send_byte(8'h96, SLOW_H, "R7 after restart");
        close_sess(SLOW_H);

        // R8: same stimulus at fast rate
        open_sess(FAST_H);
        send_byte(8'h5A, FAST_H, "R8 fast 5A");
        send_byte(8'h3C, FAST_H, "R8 fast 3C");
        send_byte(8'h00, FAST_H, "R8 fast zeros");
        send_byte(8'hC3, FAST_H, "R8 fast C3");
        close_sess(FAST_H);

        #(CLK_PERIOD * 10);
        push_check(1'b1, "R1 final idle");
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule